// File: doc/BRIEF.md
# Sector DMA Engine

This block is a peripheral controller that the processor programs through a small set of word-wide ports. Software first writes a logical block number and a destination memory address. It then writes the read-sector command. With no further processor involvement, the engine walks one sector of a local sector store word by word. It writes each word into main memory through a request/grant write port.

When the last word has been accepted, the engine raises an interrupt line and presents a fixed device identifier. Both stay up until software writes the acknowledge port. A status port shows whether a transfer is in flight and whether an interrupt is pending.

Port map (cpu_addr): 0 command, 1 block number, 2 destination address, 3 acknowledge, 4 status. A sector is 512 bytes, so it moves as 64 writes of 64 bits.

Top module: `dma_sector_engine`

## Requirements
- R1: After reset, busy and interrupt are clear, mem_req is low, irq_id is 0 and the status port (4) reads 0.
- R2: Writing the value 1 to the command port (0) while idle starts a transfer. From the next cycle, status bit 0 (busy) reads 1 and stays 1 while any memory write is pending.
- R3: A command write of any value other than 1 (0 is the no-operation code) starts nothing: busy stays 0 and mem_req stays low.
- R4: While busy, writes to the command, block number and destination ports are ignored. The running transfer is not disturbed, no second transfer follows, and the block number and destination ports (1, 2) still read back the values of the running transfer.
- R5: A transfer issues exactly 64 memory writes, in ascending order. Word k goes to destination + 8*k and carries the word that the sector store returns for (block number, k). The store interface is combinational: sto_rdata answers sto_lba/sto_idx in the same cycle.
- R6: A write is accepted in a cycle where mem_req and mem_gnt are both high. While mem_req is high and mem_gnt is low, mem_addr and mem_wdata hold stable and mem_req stays high.
- R7: The interrupt rises on the same clock edge on which busy falls after the 64th accepted write. While irq is high, irq_id equals DEV_ID (default 0x2A); otherwise irq_id is 0.
- R8: irq and status bit 1 stay high until a write to the acknowledge port (3), which clears them on that edge.
- R9: The low three bits of the destination address are forced to zero when written. The destination port reads back the aligned value, and every mem_addr is 8-byte aligned.
- R10: The block number and destination ports read back the last values written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Port write strobe |
| cpu_addr | input | 3 | Port select |
| cpu_wdata | input | DATA_W | Port write data |
| cpu_rdata | output | DATA_W | Port read data (combinational) |
| sto_lba | output | LBA_W | Sector store block number |
| sto_idx | output | IDX_W | Sector store word index |
| sto_rdata | input | DATA_W | Sector store word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory write grant |
| irq | output | 1 | Completion interrupt |
| irq_id | output | ID_W | Interrupt source identifier |

## Verification
A wrong word counter shows up directly at the memory port: the bench records every granted write. A skipped, repeated or misplaced word therefore appears as an ordering error or a wrong word count when the interrupt rises, within one sector time. A corrupted data latch or address offset gives a mismatch against the store pattern for that exact word. Sequencer state leaking past the end of a transfer shows as a busy flag or an extra request during the idle window that the bench watches after each interrupt. Interrupt latch faults show within a cycle of the completion edge or of the acknowledge write.

// File: rtl/dma_sector_pkg.sv
package dma_sector_pkg;

    localparam int PORT_AW = 3;

    localparam logic [PORT_AW-1:0] PORT_CMD  = 3'd0;
    localparam logic [PORT_AW-1:0] PORT_LBA  = 3'd1;
    localparam logic [PORT_AW-1:0] PORT_DEST = 3'd2;
    localparam logic [PORT_AW-1:0] PORT_ACK  = 3'd3;
    localparam logic [PORT_AW-1:0] PORT_STAT = 3'd4;

    localparam int CMD_NOP  = 0;
    localparam int CMD_READ = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic ack;
    } ctl_pulse_t;

    function automatic logic port_hit(input logic we,
                                      input logic [PORT_AW-1:0] addr,
                                      input logic [PORT_AW-1:0] port);
        return we && (addr == port);
    endfunction

endpackage

// File: rtl/dma_port_regs.sv
module dma_port_regs
    import dma_sector_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LBA_W  = 24,
    parameter int OFF_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_we,
    input  logic [PORT_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               busy,
    input  logic               irq,
    output logic [LBA_W-1:0]   lba_q,
    output logic [ADDR_W-1:0]  dest_q,
    output ctl_pulse_t         pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lba_q  <= '0;
            dest_q <= '0;
        end else if (!busy) begin
            if (port_hit(cpu_we, cpu_addr, PORT_LBA))
                lba_q <= cpu_wdata[LBA_W-1:0];
            if (port_hit(cpu_we, cpu_addr, PORT_DEST))
                dest_q <= {cpu_wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    always_comb begin
        pulse.start = port_hit(cpu_we, cpu_addr, PORT_CMD) && !busy &&
                      (cpu_wdata == DATA_W'(CMD_READ));
        pulse.ack   = port_hit(cpu_we, cpu_addr, PORT_ACK);
    end

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            PORT_LBA:  cpu_rdata = DATA_W'(lba_q);
            PORT_DEST: cpu_rdata = DATA_W'(dest_q);
            PORT_STAT: cpu_rdata = DATA_W'({irq, busy});
            default:   cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_sector_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LBA_W  = 24,
    parameter int WORDS  = 64,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LBA_W-1:0]  lba,
    input  logic [ADDR_W-1:0] dest,
    output logic [LBA_W-1:0]  sto_lba,
    output logic [IDX_W-1:0]  sto_idx,
    input  logic [DATA_W-1:0] sto_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done
);

    localparam int PAD_W = ADDR_W - IDX_W - OFF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept    = (state_q == SEQ_WRITE) && mem_gnt;
    assign done      = accept && (idx_q == LAST_IDX);
    assign busy      = (state_q != SEQ_IDLE);
    assign mem_req   = (state_q == SEQ_WRITE);
    assign mem_wdata = data_q;
    assign mem_addr  = dest + {{PAD_W{1'b0}}, idx_q, {OFF_W{1'b0}}};
    assign sto_lba   = lba;
    assign sto_idx   = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    idx_q <= '0;
                    if (start) state_q <= SEQ_FETCH;
                end
                SEQ_FETCH: begin
                    data_q  <= sto_rdata;
                    state_q <= SEQ_WRITE;
                end
                SEQ_WRITE: begin
                    if (accept) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= SEQ_IDLE;
                            idx_q   <= '0;
                        end else begin
                            state_q <= SEQ_FETCH;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_irq.sv
module dma_irq #(
    parameter int              ID_W   = 8,
    parameter logic [ID_W-1:0] DEV_ID = 8'h2A
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done,
    input  logic            ack,
    output logic            irq,
    output logic [ID_W-1:0] irq_id
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)       pend_q <= 1'b0;
        else if (done) pend_q <= 1'b1;
        else if (ack)  pend_q <= 1'b0;
    end

    assign irq    = pend_q;
    assign irq_id = pend_q ? DEV_ID : '0;

endmodule

// File: rtl/dma_sector_engine.sv
module dma_sector_engine
    import dma_sector_pkg::*;
#(
    parameter int              DATA_W       = 64,
    parameter int              ADDR_W       = 32,
    parameter int              LBA_W        = 24,
    parameter int              SECTOR_BYTES = 512,
    parameter int              ID_W         = 8,
    parameter logic [ID_W-1:0] DEV_ID       = 8'h2A,
    localparam int             BYTES_W      = DATA_W / 8,
    localparam int             WORDS        = SECTOR_BYTES / BYTES_W,
    localparam int             IDX_W        = $clog2(WORDS),
    localparam int             OFF_W        = $clog2(BYTES_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_we,
    input  logic [PORT_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [LBA_W-1:0]   sto_lba,
    output logic [IDX_W-1:0]   sto_idx,
    input  logic [DATA_W-1:0]  sto_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_gnt,
    output logic               irq,
    output logic [ID_W-1:0]    irq_id
);

    logic [LBA_W-1:0]  lba_q;
    logic [ADDR_W-1:0] dest_q;
    ctl_pulse_t        pulse;
    logic              busy;
    logic              done;

    dma_port_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LBA_W(LBA_W), .OFF_W(OFF_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .busy(busy), .irq(irq),
        .lba_q(lba_q), .dest_q(dest_q), .pulse(pulse)
    );

    dma_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LBA_W(LBA_W),
        .WORDS(WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(pulse.start),
        .lba(lba_q), .dest(dest_q),
        .sto_lba(sto_lba), .sto_idx(sto_idx), .sto_rdata(sto_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .busy(busy), .done(done)
    );

    dma_irq #(
        .ID_W(ID_W), .DEV_ID(DEV_ID)
    ) u_irq (
        .clk(clk), .rst(rst), .done(done), .ack(pulse.ack),
        .irq(irq), .irq_id(irq_id)
    );

endmodule

// File: rtl/dma_sector_chk.sv
module dma_sector_chk
    import dma_sector_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               mem_req,
    input logic               mem_gnt,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               irq,
    input logic               cpu_we,
    input logic [PORT_AW-1:0] cpu_addr
);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_addr_align_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cpu_we && cpu_addr == PORT_ACK)) |=> irq);

endmodule

bind dma_sector_engine dma_sector_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy),
    .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq(irq), .cpu_we(cpu_we), .cpu_addr(cpu_addr)
);

// File: tb/tb_dma_sector_engine.sv
`timescale 1ns/1ps
module tb_dma_sector_engine;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 32;
    localparam int LBA_W  = 24;
    localparam int IDX_W  = 6;
    localparam int WORDS  = 64;
    localparam logic [7:0] DEV = 8'h2A;
    localparam int NVEC   = 4;

    localparam logic [LBA_W-1:0]  T_LBA   [NVEC] = '{24'h000010, 24'hABCDEF, 24'h000000, 24'h7F0033};
    localparam logic [ADDR_W-1:0] T_DEST  [NVEC] = '{32'h0000_1000, 32'h8000_0040, 32'h0000_2003, 32'h0010_FFF8};
    localparam int                T_STALL [NVEC] = '{0, 3, 1, 0};
    localparam logic [ADDR_W-1:0] T_FIRST [NVEC] = '{32'h0000_1000, 32'h8000_0040, 32'h0000_2000, 32'h0010_FFF8};
    localparam logic [ADDR_W-1:0] T_LAST  [NVEC] = '{32'h0000_11F8, 32'h8000_0238, 32'h0000_21F8, 32'h0011_01F0};

    logic              clk = 0;
    logic              rst = 1;
    logic              cpu_we = 0;
    logic [2:0]        cpu_addr = 0;
    logic [DATA_W-1:0] cpu_wdata = 0;
    logic [DATA_W-1:0] cpu_rdata;
    logic [LBA_W-1:0]  sto_lba;
    logic [IDX_W-1:0]  sto_idx;
    logic [DATA_W-1:0] sto_rdata;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_gnt = 0;
    logic              irq;
    logic [7:0]        irq_id;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int stall_cfg = 0;
    int stall_cnt = 0;
    int wcount = 0;
    int ord_err = 0;
    int hold_err = 0;
    logic [ADDR_W-1:0] base_addr = 0;
    logic [ADDR_W-1:0] first_seen = 0;
    logic [ADDR_W-1:0] last_seen = 0;
    logic [DATA_W-1:0] img [WORDS];
    logic              hv = 0;
    logic [ADDR_W-1:0] h_a = 0;
    logic [DATA_W-1:0] h_d = 0;

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] pat(input logic [LBA_W-1:0] l, input int k);
        logic [7:0] kb;
        kb = 8'(k);
        return {l, 2'b00, kb[5:0], l ^ 24'hC3A5F0, kb ^ 8'h99};
    endfunction

    assign sto_rdata = pat(sto_lba, int'(sto_idx));

    dma_sector_engine dut (
        .clk(clk), .rst(rst),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .sto_lba(sto_lba), .sto_idx(sto_idx), .sto_rdata(sto_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .irq(irq), .irq_id(irq_id)
    );

    // Memory model: grants after stall_cfg waiting cycles, records accepted writes.
    always @(negedge clk) begin
        if (rst) begin
            mem_gnt   = 0;
            stall_cnt = 0;
            hv        = 0;
        end else begin
            if (hv && mem_req && (mem_addr != h_a || mem_wdata != h_d)) hold_err++;
            if (hv && !mem_req) hold_err++;
            hv = 0;
            if (mem_req && !mem_gnt) begin
                if (stall_cnt >= stall_cfg) begin
                    mem_gnt   = 1;
                    stall_cnt = 0;
                    if (wcount == 0) first_seen = mem_addr;
                    last_seen = mem_addr;
                    if (mem_addr < base_addr || ((mem_addr - base_addr) >> 3) != ADDR_W'(wcount)
                        || wcount >= WORDS)
                        ord_err++;
                    else
                        img[wcount] = mem_wdata;
                    wcount++;
                end else begin
                    stall_cnt++;
                    hv  = 1;
                    h_a = mem_addr;
                    h_d = mem_wdata;
                end
            end else begin
                mem_gnt = 0;
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [DATA_W-1:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
        cpu_addr = 0;
    endtask

    task automatic prep(input logic [ADDR_W-1:0] base, input int stall);
        base_addr = base;
        stall_cfg = stall;
        wcount = 0; ord_err = 0; hold_err = 0;
        for (int k = 0; k < WORDS; k++) img[k] = '0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_sector(input string req, input logic [LBA_W-1:0] l);
        int errs;
        errs = 0;
        for (int k = 0; k < WORDS; k++)
            if (img[k] !== pat(l, k)) errs++;
        check(req, 64'(errs), 64'd0);
    endtask

    logic [DATA_W-1:0] rd;
    int n;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 irq_id", 64'(irq_id), 64'd0);
        cpu_read(3'd4, rd);
        check("R1 status", rd, 64'd0);

        // Table walk: R2 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            prep(T_FIRST[v], T_STALL[v]);
            cpu_write(3'd1, 64'(T_LBA[v]));
            cpu_write(3'd2, 64'(T_DEST[v]));
            cpu_read(3'd1, rd);
            check("R10 lba readback", rd, 64'(T_LBA[v]));
            cpu_read(3'd2, rd);
            check("R9 dest aligned readback", rd, 64'(T_FIRST[v]));
            cpu_write(3'd0, 64'd1);
            cpu_read(3'd4, rd);
            check("R2 busy after start", rd, 64'd1);
            wait_irq(n);
            check("R5 word count", 64'(wcount), 64'(WORDS));
            check("R5 order", 64'(ord_err), 64'd0);
            check("R5 first addr", 64'(first_seen), 64'(T_FIRST[v]));
            check("R5 last addr", 64'(last_seen), 64'(T_LAST[v]));
            check_sector("R5 data", T_LBA[v]);
            check("R6 hold until grant", 64'(hold_err), 64'd0);
            check("R7 irq_id", 64'(irq_id), 64'(DEV));
            cpu_read(3'd4, rd);
            check("R7 busy low irq high", rd, 64'd2);
            repeat (20) @(negedge clk);
            check("R8 irq held", 64'(irq), 64'd1);
            cpu_write(3'd3, 64'd0);
            check("R8 irq cleared", 64'(irq), 64'd0);
            check("R7 irq_id cleared", 64'(irq_id), 64'd0);
        end

        // R3: no-operation and unknown codes start nothing
        prep(32'h0, 0);
        cpu_write(3'd0, 64'd0);
        cpu_read(3'd4, rd);
        check("R3 nop busy", rd, 64'd0);
        cpu_write(3'd0, 64'd3);
        repeat (10) @(negedge clk);
        cpu_read(3'd4, rd);
        check("R3 code 3 busy", rd, 64'd0);
        check("R3 no writes", 64'(wcount), 64'd0);

        // R4: writes while busy are ignored
        prep(32'h0000_4000, 2);
        cpu_write(3'd1, 64'h0000_0055);
        cpu_write(3'd2, 64'h0000_4000);
        cpu_write(3'd0, 64'd1);
        repeat (5) @(negedge clk);
        cpu_write(3'd1, 64'h0000_0099);
        cpu_write(3'd2, 64'h0000_9000);
        cpu_write(3'd0, 64'd1);
        cpu_read(3'd1, rd);
        check("R4 lba unchanged", rd, 64'h55);
        cpu_read(3'd2, rd);
        check("R4 dest unchanged", rd, 64'h4000);
        wait_irq(n);
        repeat (300) @(negedge clk);
        check("R4 single transfer", 64'(wcount), 64'(WORDS));
        check("R4 order", 64'(ord_err), 64'd0);
        check_sector("R4 data of first lba", 24'h55);
        cpu_read(3'd4, rd);
        check("R4 idle after", rd, 64'd2);
        cpu_write(3'd3, 64'd0);

        finish_run();
    end

endmodule